// File: doc/BRIEF.md
# Texture Coordinate Wrap Accumulator

This block computes the texture coordinate for one stage of a multi-stage texturing pipeline. On each valid cycle it takes the stage's S and T coordinates and an offset that arrives already computed, plus the stage's control fields. Coordinates are fixed point with seven fractional bits. Each axis is wrapped on its own. Wrapping either passes the value through, masks it to a power-of-two period of 16 to 256 texels, or forces it to zero. The offset is then added, and it is taken as zero when the lookup is disabled or names an index that is not configured. The coordinate produced last can be added on top. The sum is kept as a signed 24-bit value.

The result appears one clock after the valid input, together with a one-cycle output valid pulse. It is held in a register. That register is the "previous coordinate" the next stage accumulates onto. A first-stage flag makes the previous coordinate read as zero for that cycle. Wrapping and the add-previous step always run, whatever the state of the lookup enable.

Top module: `tcw_stage`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) drives out_valid, out_s and out_t to 0, and the previous coordinate reads as 0 after reset.
- R2: Wrap code 0 on an axis passes that axis coordinate through unchanged.
- R3: Wrap codes 1, 2, 3, 4 and 5 keep only the low 15, 14, 13, 12 and 11 bits of the axis coordinate. These are periods of 256, 128, 64, 32 and 16 texels, each shifted left by 7 fractional bits, minus one.
- R4: Wrap codes 6 and 7 both force that axis coordinate to 0.
- R5: wrap_s acts only on S and wrap_t acts only on T.
- R6: When ind_en is 1 and ind_sel < ind_count, ofs_s and ofs_t are added to the wrapped S and T.
- R7: When ind_en is 0, or ind_sel >= ind_count, the offset is taken as zero. Wrapping and add-previous still apply.
- R8: When add_prev is 1, the last produced output coordinate, per axis, is added after the offset.
- R9: When stage_first is 1 on a valid cycle, the previous coordinate reads as zero for that cycle's add-previous.
- R10: Each result component is the sum modulo 2^24, read as a signed 24-bit value.
- R11: out_valid is 1 exactly one clock after a cycle with stage_valid high. The outputs and the previous coordinate do not change after a cycle without stage_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stage_valid | input | 1 | Stage input is valid this cycle |
| stage_first | input | 1 | First stage: previous coordinate reads as zero |
| add_prev | input | 1 | Add the previous coordinate |
| ind_en | input | 1 | Indirect lookup enabled for this stage |
| ind_sel | input | 2 | Indirect stage index used by this stage |
| ind_count | input | 3 | Number of configured indirect stages (0 to 4) |
| wrap_s | input | 3 | Wrap code for S |
| wrap_t | input | 3 | Wrap code for T |
| uv_s | input | 24 | S coordinate, 7 fractional bits |
| uv_t | input | 24 | T coordinate, 7 fractional bits |
| ofs_s | input | 24 | Signed indirect offset for S |
| ofs_t | input | 24 | Signed indirect offset for T |
| out_valid | output | 1 | Result valid pulse |
| out_s | output | 24 | Resulting S coordinate, signed 24-bit |
| out_t | output | 24 | Resulting T coordinate, signed 24-bit |

## Verification
Three things can happen to one stage in the same cycle: the offset gate closing because of an out-of-range index or a cleared enable, the add-previous step, and the 24-bit overflow. The bench provokes this with vectors that pair a disabled or out-of-range offset with add_prev set. It also uses sums that cross the signed 24-bit boundary. Each vector is judged against a hand-computed expected pair. The vectors are chained, so each expected value also depends on the output kept from the vector before it.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

  localparam int unsigned WRAP_W = 3;

  typedef enum logic [WRAP_W-1:0] {
    WRAP_NONE = 3'd0,
    WRAP_P256 = 3'd1,
    WRAP_P128 = 3'd2,
    WRAP_P64  = 3'd3,
    WRAP_P32  = 3'd4,
    WRAP_P16  = 3'd5,
    WRAP_ZERO = 3'd6,
    WRAP_BAD  = 3'd7
  } wrap_code_e;

  // number of low coordinate bits a wrap code keeps (pass-through handled apart)
  function automatic int unsigned wrap_keep_bits(input wrap_code_e code,
                                                 input int unsigned frac_w,
                                                 input int unsigned max_log2);
    int unsigned step;
    if (code == WRAP_ZERO || code == WRAP_BAD || code == WRAP_NONE) begin
      wrap_keep_bits = 0;
    end else begin
      step = int'(code) - int'(WRAP_P256);
      wrap_keep_bits = frac_w + max_log2 - step;
    end
  endfunction

endpackage

// File: rtl/tcw_axis_wrap.sv
module tcw_axis_wrap
  import tcw_pkg::*;
#(
  parameter int unsigned COORD_W  = 24,
  parameter int unsigned FRAC_W   = 7,
  parameter int unsigned MAX_LOG2 = 8
) (
  input  logic [COORD_W-1:0] coord_in,
  input  logic [WRAP_W-1:0]  code,
  output logic [COORD_W-1:0] coord_out
);

  wrap_code_e       code_e;
  int unsigned      keep;
  logic [COORD_W-1:0] keep_mask;

  assign code_e = wrap_code_e'(code);
  assign keep   = wrap_keep_bits(code_e, FRAC_W, MAX_LOG2);

  for (genvar b = 0; b < COORD_W; b++) begin : g_mask
    assign keep_mask[b] = (b < keep);
  end

  always_comb begin
    if (code_e == WRAP_NONE) begin
      coord_out = coord_in;
    end else begin
      coord_out = coord_in & keep_mask;
    end
  end

endmodule

// File: rtl/tcw_ofs_gate.sv
module tcw_ofs_gate #(
  parameter int unsigned COORD_W = 24,
  parameter int unsigned IDX_W   = 2,
  localparam int unsigned CNT_W  = IDX_W + 1
) (
  input  logic               ind_en,
  input  logic [IDX_W-1:0]   ind_sel,
  input  logic [CNT_W-1:0]   ind_count,
  input  logic [COORD_W-1:0] ofs_s,
  input  logic [COORD_W-1:0] ofs_t,
  output logic               ofs_live,
  output logic [COORD_W-1:0] ofs_s_g,
  output logic [COORD_W-1:0] ofs_t_g
);

  logic idx_in_range;

  assign idx_in_range = ({1'b0, ind_sel} < ind_count);
  assign ofs_live     = ind_en & idx_in_range;
  assign ofs_s_g      = ofs_live ? ofs_s : '0;
  assign ofs_t_g      = ofs_live ? ofs_t : '0;

endmodule

// File: rtl/tcw_accum.sv
module tcw_accum #(
  parameter int unsigned COORD_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stage_valid,
  input  logic               stage_first,
  input  logic               add_prev,
  input  logic [COORD_W-1:0] wrap_s,
  input  logic [COORD_W-1:0] wrap_t,
  input  logic [COORD_W-1:0] ofs_s,
  input  logic [COORD_W-1:0] ofs_t,
  output logic               out_valid,
  output logic [COORD_W-1:0] out_s,
  output logic [COORD_W-1:0] out_t
);

  localparam int unsigned SUM_W = COORD_W + 2;

  // sum of three terms, widened, then reduced back to the signed coordinate width
  function automatic logic [COORD_W-1:0] acc_axis(input logic [COORD_W-1:0] w,
                                                  input logic [COORD_W-1:0] o,
                                                  input logic [COORD_W-1:0] p);
    logic [SUM_W-1:0] wide;
    wide = {{2{w[COORD_W-1]}}, w} + {{2{o[COORD_W-1]}}, o} + {{2{p[COORD_W-1]}}, p};
    acc_axis = wide[COORD_W-1:0];
  endfunction

  logic [COORD_W-1:0] prev_s, prev_t;
  logic [COORD_W-1:0] sum_s, sum_t;

  assign prev_s = (add_prev && !stage_first) ? out_s : '0;
  assign prev_t = (add_prev && !stage_first) ? out_t : '0;
  assign sum_s  = acc_axis(wrap_s, ofs_s, prev_s);
  assign sum_t  = acc_axis(wrap_t, ofs_t, prev_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_s     <= '0;
      out_t     <= '0;
    end else begin
      out_valid <= stage_valid;
      if (stage_valid) begin
        out_s <= sum_s;
        out_t <= sum_t;
      end
    end
  end

endmodule

// File: rtl/tcw_stage.sv
module tcw_stage
  import tcw_pkg::*;
#(
  parameter int unsigned COORD_W  = 24,
  parameter int unsigned FRAC_W   = 7,
  parameter int unsigned MAX_LOG2 = 8,
  parameter int unsigned IDX_W    = 2,
  localparam int unsigned CNT_W   = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stage_valid,
  input  logic               stage_first,
  input  logic               add_prev,
  input  logic               ind_en,
  input  logic [IDX_W-1:0]   ind_sel,
  input  logic [CNT_W-1:0]   ind_count,
  input  logic [WRAP_W-1:0]  wrap_s,
  input  logic [WRAP_W-1:0]  wrap_t,
  input  logic [COORD_W-1:0] uv_s,
  input  logic [COORD_W-1:0] uv_t,
  input  logic [COORD_W-1:0] ofs_s,
  input  logic [COORD_W-1:0] ofs_t,
  output logic               out_valid,
  output logic [COORD_W-1:0] out_s,
  output logic [COORD_W-1:0] out_t
);

  localparam int unsigned AXES = 2;

  logic [AXES-1:0][COORD_W-1:0] axis_in;
  logic [AXES-1:0][WRAP_W-1:0]  axis_code;
  logic [AXES-1:0][COORD_W-1:0] axis_wrapped;

  // named internal events for the checker
  logic [COORD_W-1:0] wrapped_s, wrapped_t;
  logic [COORD_W-1:0] ofs_s_g, ofs_t_g;
  logic               ofs_live;

  assign axis_in[0]   = uv_s;
  assign axis_in[1]   = uv_t;
  assign axis_code[0] = wrap_s;
  assign axis_code[1] = wrap_t;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    tcw_axis_wrap #(
      .COORD_W (COORD_W),
      .FRAC_W  (FRAC_W),
      .MAX_LOG2(MAX_LOG2)
    ) u_wrap (
      .coord_in (axis_in[a]),
      .code     (axis_code[a]),
      .coord_out(axis_wrapped[a])
    );
  end

  assign wrapped_s = axis_wrapped[0];
  assign wrapped_t = axis_wrapped[1];

  tcw_ofs_gate #(
    .COORD_W(COORD_W),
    .IDX_W  (IDX_W)
  ) u_gate (
    .ind_en   (ind_en),
    .ind_sel  (ind_sel),
    .ind_count(ind_count),
    .ofs_s    (ofs_s),
    .ofs_t    (ofs_t),
    .ofs_live (ofs_live),
    .ofs_s_g  (ofs_s_g),
    .ofs_t_g  (ofs_t_g)
  );

  tcw_accum #(
    .COORD_W(COORD_W)
  ) u_acc (
    .clk        (clk),
    .rst        (rst),
    .stage_valid(stage_valid),
    .stage_first(stage_first),
    .add_prev   (add_prev),
    .wrap_s     (wrapped_s),
    .wrap_t     (wrapped_t),
    .ofs_s      (ofs_s_g),
    .ofs_t      (ofs_t_g),
    .out_valid  (out_valid),
    .out_s      (out_s),
    .out_t      (out_t)
  );

endmodule

// File: rtl/tcw_stage_chk.sv
module tcw_stage_chk #(
  parameter int unsigned COORD_W  = 24,
  parameter int unsigned FRAC_W   = 7,
  parameter int unsigned MAX_LOG2 = 8,
  parameter int unsigned IDX_W    = 2,
  localparam int unsigned CNT_W   = IDX_W + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               stage_valid,
  input logic               stage_first,
  input logic [IDX_W-1:0]   ind_sel,
  input logic [CNT_W-1:0]   ind_count,
  input logic [2:0]         wrap_s,
  input logic [COORD_W-1:0] uv_s,
  input logic [COORD_W-1:0] wrapped_s,
  input logic               ofs_live,
  input logic               out_valid,
  input logic [COORD_W-1:0] out_s,
  input logic [COORD_W-1:0] out_t
);

  localparam int unsigned PERIOD_BITS = FRAC_W + MAX_LOG2;

  AST_WRAP_PASS: assert property (@(posedge clk) disable iff (rst)
    (stage_valid && wrap_s == 3'd0) |-> (wrapped_s == uv_s)); // R2

  AST_WRAP_RANGE: assert property (@(posedge clk) disable iff (rst)
    (stage_valid && wrap_s >= 3'd1 && wrap_s <= 3'd5) |-> ((wrapped_s >> PERIOD_BITS) == '0)); // R3

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stage_valid && wrap_s >= 3'd6) |-> (wrapped_s == '0)); // R4

  AST_OFS_GATED: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, ind_sel} >= ind_count) |-> !ofs_live); // R7

  AST_FIRST_NO_PREV: assert property (@(posedge clk) disable iff (rst)
    (stage_valid && stage_first && wrap_s == 3'd0 && !ofs_live) |=> (out_s == $past(uv_s))); // R9

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    stage_valid |=> out_valid); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !stage_valid |=> (!out_valid && $stable(out_s) && $stable(out_t))); // R11

endmodule

bind tcw_stage tcw_stage_chk #(
  .COORD_W (COORD_W),
  .FRAC_W  (FRAC_W),
  .MAX_LOG2(MAX_LOG2),
  .IDX_W   (IDX_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stage_valid(stage_valid),
  .stage_first(stage_first),
  .ind_sel    (ind_sel),
  .ind_count  (ind_count),
  .wrap_s     (wrap_s),
  .uv_s       (uv_s),
  .wrapped_s  (wrapped_s),
  .ofs_live   (ofs_live),
  .out_valid  (out_valid),
  .out_s      (out_s),
  .out_t      (out_t)
);

// File: tb/tcw_stage_bench.sv
module tcw_stage_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stage_valid = 1'b0, stage_first = 1'b0, add_prev = 1'b0, ind_en = 1'b0;
  logic [1:0]  ind_sel = '0;
  logic [2:0]  ind_count = '0, wrap_s = '0, wrap_t = '0;
  logic [23:0] uv_s = '0, uv_t = '0, ofs_s = '0, ofs_t = '0;
  logic        out_valid;
  logic [23:0] out_s, out_t;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tcw_stage u_tcw_stage (
    .clk(clk), .rst(rst), .stage_valid(stage_valid), .stage_first(stage_first),
    .add_prev(add_prev), .ind_en(ind_en), .ind_sel(ind_sel), .ind_count(ind_count),
    .wrap_s(wrap_s), .wrap_t(wrap_t), .uv_s(uv_s), .uv_t(uv_t),
    .ofs_s(ofs_s), .ofs_t(ofs_t), .out_valid(out_valid), .out_s(out_s), .out_t(out_t)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        first;
    logic        ap;
    logic        en;
    logic [1:0]  sel;
    logic [2:0]  cnt;
    logic [2:0]  ws;
    logic [2:0]  wt;
    logic [23:0] s;
    logic [23:0] t;
    logic [23:0] os;
    logic [23:0] ot;
    logic [23:0] es;
    logic [23:0] et;
  } vec_t;

  localparam int NV = 11;
  // chained vectors: each expected value depends on the previous row's output
  localparam vec_t VECS [NV] = '{
    // R2 pass-through
    '{4'd2,  1'b1,1'b0,1'b1,2'd0,3'd1,3'd0,3'd0,24'h012345,24'h7FFF00,24'h0,24'h0,24'h012345,24'h7FFF00},
    // R3 / R5 codes 1 and 5 on separate axes
    '{4'd3,  1'b0,1'b0,1'b1,2'd0,3'd1,3'd1,3'd5,24'h0ABCDE,24'h0ABCDE,24'h0,24'h0,24'h003CDE,24'h0004DE},
    // R3 codes 2 and 3
    '{4'd3,  1'b0,1'b0,1'b1,2'd0,3'd1,3'd2,3'd3,24'hFFFFFF,24'hFFFFFF,24'h0,24'h0,24'h003FFF,24'h001FFF},
    // R4 / R5 code 4 on S, code 6 on T
    '{4'd4,  1'b0,1'b0,1'b1,2'd0,3'd1,3'd4,3'd6,24'h123456,24'h123456,24'h0,24'h0,24'h000456,24'h000000},
    // R6 offset applied, code 7 zeroes S
    '{4'd6,  1'b0,1'b0,1'b1,2'd1,3'd2,3'd7,3'd0,24'h555555,24'h000010,24'h000100,24'hFFFFF0,24'h000100,24'h000000},
    // R7 index at count: offset dropped
    '{4'd7,  1'b0,1'b0,1'b1,2'd2,3'd2,3'd7,3'd0,24'h555555,24'h000010,24'h000100,24'hFFFFF0,24'h000000,24'h000010},
    // R8 with R7: lookup disabled, add-previous still runs
    '{4'd8,  1'b0,1'b1,1'b0,2'd0,3'd4,3'd0,3'd0,24'h000005,24'h000007,24'h111111,24'h111111,24'h000005,24'h000017},
    // R10 signed overflow on both axes
    '{4'd10, 1'b0,1'b1,1'b1,2'd3,3'd4,3'd0,3'd0,24'h7FFFFF,24'h800000,24'h000001,24'hFFFFFF,24'h800005,24'h800016},
    // R9 first stage ignores previous
    '{4'd9,  1'b1,1'b1,1'b0,2'd0,3'd4,3'd1,3'd6,24'h00FFFF,24'h000123,24'h0,24'h0,24'h007FFF,24'h000000},
    // R10 wrap-around, count 0 drops offset (R7), prev added (R8)
    '{4'd10, 1'b0,1'b1,1'b1,2'd0,3'd0,3'd0,3'd0,24'hFFFFFF,24'h000001,24'h000005,24'h000005,24'h007FFE,24'h000001},
    // R6 with R8: wrap, offset and previous together
    '{4'd6,  1'b0,1'b1,1'b1,2'd1,3'd3,3'd3,3'd5,24'hFFFFFF,24'hFFFFFF,24'h000001,24'hFFF800,24'h009FFE,24'h000000}
  };

  task automatic check(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic valid);
    @(negedge clk);
    stage_valid = valid;  stage_first = v.first; add_prev = v.ap; ind_en = v.en;
    ind_sel = v.sel;      ind_count = v.cnt;     wrap_s = v.ws;   wrap_t = v.wt;
    uv_s = v.s; uv_t = v.t; ofs_s = v.os; ofs_t = v.ot;
    @(posedge clk);
    #1;
  endtask

  initial begin
    vec_t v;
    string tag;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "out_valid", {23'd0, out_valid}, 24'd0);
    check("R1", "out_s", out_s, 24'd0);
    check("R1", "out_t", out_t, 24'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      tag = $sformatf("R%0d", VECS[i].req);
      check(tag, $sformatf("vec%0d s", i), out_s, VECS[i].es);
      check(tag, $sformatf("vec%0d t", i), out_t, VECS[i].et);
      check("R11", $sformatf("vec%0d valid", i), {23'd0, out_valid}, 24'd1);
    end

    // R11 idle cycles change nothing
    v = '{4'd11, 1'b1,1'b1,1'b1,2'd0,3'd4,3'd0,3'd0,24'h333333,24'h444444,24'h1,24'h1,24'h0,24'h0};
    for (int k = 0; k < 2; k++) begin
      drive(v, 1'b0);
      check("R11", "idle valid", {23'd0, out_valid}, 24'd0);
      check("R11", "idle hold s", out_s, 24'h009FFE);
      check("R11", "idle hold t", out_t, 24'h000000);
    end
    // R11 previous untouched by idle cycles: add zero plus previous
    v = '{4'd11, 1'b0,1'b1,1'b0,2'd0,3'd4,3'd0,3'd0,24'h0,24'h0,24'h0,24'h0,24'h0,24'h0};
    drive(v, 1'b1);
    check("R11", "prev kept s", out_s, 24'h009FFE);
    check("R11", "prev kept t", out_t, 24'h000000);

    // R1 reset mid-run clears outputs and previous
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1", "mid reset valid", {23'd0, out_valid}, 24'd0);
    check("R1", "mid reset s", out_s, 24'd0);
    @(negedge clk);
    rst = 1'b0;
    v = '{4'd1, 1'b0,1'b1,1'b0,2'd0,3'd4,3'd0,3'd0,24'h000003,24'h000004,24'h0,24'h0,24'h0,24'h0};
    drive(v, 1'b1);
    check("R1", "prev cleared s", out_s, 24'h000003);
    check("R1", "prev cleared t", out_t, 24'h000004);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule